// File: doc/BRIEF.md
# Sync Selector and One-Shot Generator

This block creates the sync strobes that restart the control counters of a multi-channel upconverter and drives a sync output pin. There are three sync consumers: the interpolation control counter, a free-running terminal-count counter, and the output pin. Each consumer has its own 2-bit source field in a sync mode register. That field picks one of four sources: no sync, the external sync input, the terminal-count source, or a sync that is always active.

The external sync input comes from another clock domain. It passes through a two-flop synchronizer and a rising-edge detector before any consumer uses it. A one-shot sync is fired by setting a control bit in the mode register. In pulse mode it gives one single-cycle strobe per set of the bit. In level mode it stays active for as long as the bit is held. A use-one-shot bit lets the one-shot stand in wherever the terminal-count source is selected. The free-running counter has a programmable period. It reloads whenever its own selected sync arrives.

Configuration is written through a small register port with three addresses: the mode register, the one-shot style bit and the counter period.

Top module: `sync_strobe_gen`

## Requirements
- R1: After reset the mode register holds 0x69. So the interpolation sync follows the external input, the counter sync and the pin follow the one-shot, the one-shot is armed-off in pulse mode, the period is 15, and `sync_out_n_o` is high.
- R2: Field layout of the mode register at address 0:
  - bits [1:0] select the interpolation sync source.
  - bits [3:2] select the counter sync source.
  - bits [5:4] select the pin sync source.
  - bit 6 is use-one-shot.
  - bit 7 is the one-shot bit.

  The source codes are: 0 gives no sync, 1 gives the external sync, 2 gives the terminal-count source, and 3 gives a sync that is always active. The interpolation strobe `intp_sync_o` and the counter strobe `tcnt_sync_o` are combinational from the selection.
- R3: A rising edge on `ext_sync_i` produces exactly one single-cycle external sync event, however long the input stays high. The event is visible in the cycle after the second rising clock edge that samples the input high.
- R4: In pulse mode (address 1, bit 0 = 0), a write that sets bit 7 produces a one-shot strobe in the cycle right after the write edge, for exactly one cycle.
- R5: In level mode (address 1, bit 0 = 1), the one-shot is active in every cycle in which bit 7 is set.
- R6: In pulse mode, holding bit 7 set produces no further strobes. Clearing the bit and then setting it again produces a new strobe.
- R7: For source code 2 on the interpolation and pin fields, the terminal-count pulse is used when bit 6 is 0. The one-shot is used in its place when bit 6 is 1. For the counter field, code 2 always means the one-shot.
- R8: The counter runs down from period P (address 2) to 0. It shows `tc_pulse_o` for one cycle at count 0, so the pulse repeats every P+1 cycles. In a cycle where `tcnt_sync_o` is high, the counter reloads to P. If P is above 0, the next cycle then carries no terminal-count pulse.
- R9: `sync_out_n_o` is a register. In each cycle it carries the inverse of the pin's selected sync from the previous cycle.
- R10: A write with `cfg_we_i` high takes effect from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address: 0 mode, 1 one-shot style, 2 period |
| cfg_wdata_i | input | DATA_W | Register write data |
| ext_sync_i | input | 1 | Asynchronous external sync input |
| intp_sync_o | output | 1 | Sync strobe to the interpolation counter |
| tcnt_sync_o | output | 1 | Sync strobe that reloads the terminal-count counter |
| tc_pulse_o | output | 1 | Terminal-count pulse |
| sync_out_n_o | output | 1 | Inverted, registered sync for the output pin |

## Verification
A wrong edge-detector or synchronizer state shows up on `intp_sync_o` two to three cycles after a change on `ext_sync_i`. It appears as a missing, late or repeated strobe. A stale one-shot history flop shows up the cycle after a write, as a second strobe or a missing strobe. A wrong count shows up on `tc_pulse_o` within one period at most. The bench runs a behavioural model every cycle, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/sync_strobe_pkg.sv
`timescale 1ns/1ps
// Shared types for the sync selector.
// Assumes: source codes are fixed by the mode register layout.
package sync_strobe_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_TC   = 2'd2,
        SRC_ON   = 2'd3
    } sync_src_e;

    localparam int unsigned NUM_CONSUMERS = 3;
    localparam int unsigned CONS_INTP = 0;
    localparam int unsigned CONS_TCNT = 1;
    localparam int unsigned CONS_PIN  = 2;

    localparam logic [7:0] MODE_RST = 8'h69;

endpackage

// File: rtl/sync_ext_edge.sv
`timescale 1ns/1ps
// Brings the external sync into the clock domain and flags its rising edge.
// Assumes: input is asynchronous; one event per low-to-high transition.
module sync_ext_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic evt_o
);
    localparam int unsigned LAST = SYNC_STAGES;

    logic [LAST:0] chain_q;

    // Shift the input through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], async_i};
        end
    end

    assign evt_o = chain_q[LAST-1] & ~chain_q[LAST];

endmodule

// File: rtl/sync_oneshot.sv
`timescale 1ns/1ps
// One-shot sync: a single-cycle strobe on each set of the arm bit, or a
// level that follows the bit.
// Assumes: arm_i is a register output.
module sync_oneshot (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic level_i,
    output logic evt_o
);
    logic arm_prev_q;

    // Remember last cycle's arm bit so that a held bit cannot re-fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_prev_q <= 1'b0;
        end else begin
            arm_prev_q <= arm_i;
        end
    end

    // Pick the strobe style.
    always_comb begin
        if (level_i) begin
            evt_o = arm_i;
        end else begin
            evt_o = arm_i & ~arm_prev_q;
        end
    end

endmodule

// File: rtl/sync_tc_counter.sv
`timescale 1ns/1ps
// Free-running down counter that gives a terminal-count pulse at zero and
// reloads on wrap or on its sync.
// Assumes: period_i is stable between writes.
module sync_tc_counter #(
    parameter int unsigned          W          = 8,
    parameter logic [W-1:0]         RST_PERIOD = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period_i,
    input  logic         reload_i,
    output logic         tc_o
);
    logic [W-1:0] cnt_q;

    assign tc_o = (cnt_q == '0);

    // Count down; reload on sync or after the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_PERIOD;
        end else if (reload_i || tc_o) begin
            cnt_q <= period_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/sync_src_mux.sv
`timescale 1ns/1ps
// Picks one sync source from a 2-bit code.
// Assumes: the code follows sync_src_e.
module sync_src_mux
    import sync_strobe_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       ext_i,
    input  logic       tc_i,
    output logic       sync_o
);
    // Decode the source code.
    always_comb begin
        unique case (sync_src_e'(mode_i))
            SRC_NONE: sync_o = 1'b0;
            SRC_EXT:  sync_o = ext_i;
            SRC_TC:   sync_o = tc_i;
            SRC_ON:   sync_o = 1'b1;
            default:  sync_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sync_strobe_gen.sv
`timescale 1ns/1ps
// Top: configuration registers, external sync conditioning, one-shot,
// terminal-count counter and three source selectors.
// Assumes: writes and the sync output share clk; reset is synchronous.
module sync_strobe_gen
    import sync_strobe_pkg::*;
#(
    parameter int unsigned       DATA_W      = 8,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] PERIOD_RST  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              ext_sync_i,
    output logic              intp_sync_o,
    output logic              tcnt_sync_o,
    output logic              tc_pulse_o,
    output logic              sync_out_n_o
);
    localparam logic [1:0] ADDR_MODE  = 2'd0;
    localparam logic [1:0] ADDR_STYLE = 2'd1;
    localparam logic [1:0] ADDR_PER   = 2'd2;

    logic [7:0]        mode_q;
    logic              os_level_q;
    logic [DATA_W-1:0] period_q;
    logic              ext_evt;
    logic              os_evt;
    logic              tc_evt;
    logic              tc_src;
    logic [NUM_CONSUMERS-1:0][1:0] mode_f;
    logic [NUM_CONSUMERS-1:0]      tc_in;
    logic [NUM_CONSUMERS-1:0]      sel;
    logic              out_sel;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_RST;
            os_level_q <= 1'b0;
            period_q   <= PERIOD_RST;
        end else if (cfg_we_i) begin
            case (cfg_addr_i)
                ADDR_MODE:  mode_q     <= cfg_wdata_i[7:0];
                ADDR_STYLE: os_level_q <= cfg_wdata_i[0];
                ADDR_PER:   period_q   <= cfg_wdata_i;
                default:    ;
            endcase
        end
    end

    sync_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_sync_i),
        .evt_o   (ext_evt)
    );

    sync_oneshot u_os (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (mode_q[7]),
        .level_i (os_level_q),
        .evt_o   (os_evt)
    );

    sync_tc_counter #(.W(DATA_W), .RST_PERIOD(PERIOD_RST)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_q),
        .reload_i (tcnt_sync_o),
        .tc_o     (tc_evt)
    );

    // The one-shot replaces the terminal count when use-one-shot is set.
    assign tc_src = mode_q[6] ? os_evt : tc_evt;

    // Per-consumer fields and terminal-count-slot source.
    always_comb begin
        mode_f[CONS_INTP] = mode_q[1:0];
        mode_f[CONS_TCNT] = mode_q[3:2];
        mode_f[CONS_PIN]  = mode_q[5:4];
        tc_in[CONS_INTP]  = tc_src;
        tc_in[CONS_TCNT]  = os_evt;
        tc_in[CONS_PIN]   = tc_src;
    end

    for (genvar g = 0; g < NUM_CONSUMERS; g++) begin : g_sel
        sync_src_mux u_mux (
            .mode_i (mode_f[g]),
            .ext_i  (ext_evt),
            .tc_i   (tc_in[g]),
            .sync_o (sel[g])
        );
    end

    assign intp_sync_o = sel[CONS_INTP];
    assign tcnt_sync_o = sel[CONS_TCNT];
    assign tc_pulse_o  = tc_evt;
    assign out_sel     = sel[CONS_PIN];

    // Register and invert the pin sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_out_n_o <= 1'b1;
        end else begin
            sync_out_n_o <= ~out_sel;
        end
    end

endmodule

// File: rtl/sync_strobe_gen_chk.sv
`timescale 1ns/1ps
// Checker for sync_strobe_gen: timing rules of the strobes.
// Assumes: bound to every instance of sync_strobe_gen.
module sync_strobe_gen_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_evt,
    input logic              os_evt,
    input logic              os_level_q,
    input logic              out_sel,
    input logic              tcnt_sync_o,
    input logic              tc_pulse_o,
    input logic              sync_out_n_o,
    input logic [DATA_W-1:0] period_q
);
    // R3: an external event lasts one cycle.
    p_ext_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt |=> !ext_evt);

    // R4 / R6: a pulse-mode one-shot lasts one cycle.
    p_os_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (os_evt && !os_level_q) |=> (!os_evt || os_level_q));

    // R8: a reload with a nonzero period suppresses the next terminal count.
    p_reload_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt_sync_o && period_q != '0) |=> !tc_pulse_o);

    // R9: the pin carries the inverted selection one cycle later.
    p_pin_inverted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_out_n_o == !$past(out_sel)));

endmodule

bind sync_strobe_gen sync_strobe_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_evt      (ext_evt),
    .os_evt       (os_evt),
    .os_level_q   (os_level_q),
    .out_sel      (out_sel),
    .tcnt_sync_o  (tcnt_sync_o),
    .tc_pulse_o   (tc_pulse_o),
    .sync_out_n_o (sync_out_n_o),
    .period_q     (period_q)
);

// File: tb/sync_strobe_gen_bench.sv
`timescale 1ns/1ps
module sync_strobe_gen_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we_i = 1'b0;
    logic [1:0]   cfg_addr_i = '0;
    logic [W-1:0] cfg_wdata_i = '0;
    logic         ext_sync_i = 1'b0;
    logic         intp_sync_o, tcnt_sync_o, tc_pulse_o, sync_out_n_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sync_strobe_gen u_sync_strobe_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .ext_sync_i(ext_sync_i),
        .intp_sync_o(intp_sync_o), .tcnt_sync_o(tcnt_sync_o),
        .tc_pulse_o(tc_pulse_o), .sync_out_n_o(sync_out_n_o)
    );

    // ---------------- reference model ----------------
    bit m_s1, m_s2, m_s3, m_osp, m_lvl, m_out_n;
    bit [7:0] m_mode;
    int m_per, m_cnt;

    function automatic bit pick(input bit [1:0] code, input bit e, input bit t);
        case (code)
            2'd0: return 1'b0;
            2'd1: return e;
            2'd2: return t;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit m_ext();
        return m_s2 && !m_s3;
    endfunction
    function automatic bit m_os();
        return m_lvl ? m_mode[7] : (m_mode[7] && !m_osp);
    endfunction
    function automatic bit m_tcslot();
        return m_mode[6] ? m_os() : (m_cnt == 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_osp = 0; m_lvl = 0; m_out_n = 1;
            m_mode = 8'h69; m_per = 15; m_cnt = 15;
        end else begin
            bit reload;
            reload = pick(m_mode[3:2], m_ext(), m_os());
            m_out_n = !pick(m_mode[5:4], m_ext(), m_tcslot());
            if (reload || m_cnt == 0) m_cnt = m_per; else m_cnt = m_cnt - 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_sync_i;
            m_osp = m_mode[7];
            if (cfg_we_i) begin
                case (cfg_addr_i)
                    2'd0: m_mode = cfg_wdata_i;
                    2'd1: m_lvl = cfg_wdata_i[0];
                    2'd2: m_per = int'(cfg_wdata_i);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison and strobe counters.
    int n_intp = 0, n_tcnt = 0, n_tc = 0, n_pin = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(intp_sync_o == pick(m_mode[1:0], m_ext(), m_tcslot()), "R2 intp", intp_sync_o,
                  pick(m_mode[1:0], m_ext(), m_tcslot()));
            check(tcnt_sync_o == pick(m_mode[3:2], m_ext(), m_os()), "R2 tcnt", tcnt_sync_o,
                  pick(m_mode[3:2], m_ext(), m_os()));
            check(tc_pulse_o == (m_cnt == 0), "R8 tc", tc_pulse_o, int'(m_cnt == 0));
            check(sync_out_n_o == m_out_n, "R9 pin", sync_out_n_o, m_out_n);
            if (intp_sync_o) n_intp++;
            if (tcnt_sync_o) n_tcnt++;
            if (tc_pulse_o) n_tc++;
            if (!sync_out_n_o) n_pin++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        @(negedge clk); #1;
        cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk); #1;
        cfg_we_i = 0;
    endtask

    task automatic set_ext(input bit v);
        @(negedge clk); #1;
        ext_sync_i = v;
    endtask

    initial begin
        int s_i, s_t, s_c, s_p;
        idle(3);
        #1 rst_n = 1;
        @(negedge clk);
        check(sync_out_n_o == 1'b1, "R1 pin idle", sync_out_n_o, 1);
        check(tc_pulse_o == 1'b0, "R1 tc idle", tc_pulse_o, 0);

        // R3 / R1: external sync held high gives one interpolation strobe.
        s_i = n_intp; s_t = n_tcnt;
        set_ext(1); idle(6); set_ext(0); idle(4);
        check(n_intp - s_i == 1, "R3 ext single", n_intp - s_i, 1);
        check(n_tcnt - s_t == 0, "R1 counter not on ext", n_tcnt - s_t, 0);

        // R4 / R9: pulse-mode one-shot.
        s_t = n_tcnt; s_p = n_pin;
        @(negedge clk); #1; cfg_we_i = 1; cfg_addr_i = 0; cfg_wdata_i = 8'hE9;
        @(negedge clk);
        check(tcnt_sync_o == 1'b1, "R4 next cycle", tcnt_sync_o, 1);
        #1 cfg_we_i = 0;
        idle(6);
        check(n_tcnt - s_t == 1, "R4 one strobe", n_tcnt - s_t, 1);
        check(n_pin - s_p == 1, "R9 one pin low", n_pin - s_p, 1);

        // R6: held bit gives nothing more; re-arm gives another.
        s_t = n_tcnt; idle(5);
        check(n_tcnt - s_t == 0, "R6 held", n_tcnt - s_t, 0);
        wr(0, 8'h69); wr(0, 8'hE9); idle(3);
        check(n_tcnt - s_t == 1, "R6 rearm", n_tcnt - s_t, 1);
        wr(0, 8'h69);

        // R5: level mode active for as long as the bit is set.
        wr(1, 8'h01);
        s_t = n_tcnt;
        @(negedge clk); #1; cfg_we_i = 1; cfg_addr_i = 0; cfg_wdata_i = 8'hE9;
        @(negedge clk); #1; cfg_we_i = 0;
        idle(4);
        @(negedge clk); #1; cfg_we_i = 1; cfg_wdata_i = 8'h69;
        @(negedge clk); #1; cfg_we_i = 0;
        idle(3);
        check(n_tcnt - s_t == 6, "R5 level length", n_tcnt - s_t, 6);
        wr(1, 8'h00);

        // R8 / R10: period 5 gives a pulse every 6 cycles on the tc slot.
        wr(2, 8'd5); wr(0, 8'h22); idle(2);
        s_i = n_intp; idle(30);
        check(n_intp - s_i == 5, "R10 period 5", n_intp - s_i, 5);

        // R7: use-one-shot hides the terminal count from the tc slot.
        wr(0, 8'h62);
        s_i = n_intp; s_c = n_tc; idle(20);
        check(n_intp - s_i == 0, "R7 replaced", n_intp - s_i, 0);
        check(n_tc - s_c >= 3, "R7 counter running", n_tc - s_c, 3);

        // R8: frequent external syncs keep reloading the counter.
        wr(0, 8'h26);
        for (int k = 0; k < 2; k++) begin set_ext(1); idle(1); set_ext(0); idle(1); end
        s_c = n_tc;
        for (int k = 0; k < 6; k++) begin set_ext(1); idle(1); set_ext(0); idle(1); end
        check(n_tc - s_c == 0, "R8 reload", n_tc - s_c, 0);

        // R2: code 3 always on, code 0 never.
        wr(0, 8'h3F); idle(3);
        check(intp_sync_o == 1'b1, "R2 always intp", intp_sync_o, 1);
        check(sync_out_n_o == 1'b0, "R2 always pin", sync_out_n_o, 0);
        wr(0, 8'h00); idle(3);
        s_i = n_intp; set_ext(1); idle(5); set_ext(0); idle(2);
        check(n_intp - s_i == 0, "R2 none", n_intp - s_i, 0);
        check(sync_out_n_o == 1'b1, "R2 none pin", sync_out_n_o, 1);

        // R8: period 0 pulses every cycle.
        wr(2, 8'd0); wr(0, 8'h22); idle(20);
        s_c = n_tc; idle(5);
        check(n_tc - s_c == 5, "R8 period 0", n_tc - s_c, 5);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule